// File: doc/BRIEF.md
# Configuration Register Commit Controller

This block keeps a small bank of working configuration registers and decides when each one is copied into a nonvolatile store. Register 0 is the address/control register: bit 3 is the write-control flag and bits 2:0 are the device-select code. Every other bit of register 0 is reserved and is held at zero. Registers 1 and up are ordinary data registers. A register-write front end delivers write events (selector and data). It can also pulse an explicit commit command. The store is reached through a request pulse carrying address and data. It answers with a busy level and a done pulse.

When the write-control flag is clear, every write is committed automatically. When it is set, ordinary writes are only remembered as modified until the next commit command. Writes to register 0 are always committed at once, whatever the flag says. Each register has a pending flag. Commits that arrive while the store is busy are held in these flags and are issued lowest index first once the store is free. Reads always see the newest written value.

The sequencer has three states. ST_IDLE waits until some register is pending and the store is not busy; it then captures the lowest pending register and moves to ST_SEND. ST_SEND drives the request for one cycle and always moves on to ST_WAIT. ST_WAIT holds until the store's done pulse and then returns to ST_IDLE.

Top module: `cfg_commit_ctrl`

## Requirements
- R1: After reset, wc_bit is 0 and dev_sel is 000. Every working register reads 0 (register 0 and the ordinary default `ORD_DEFAULT` = 0). nv_req stays low while no register is pending.
- R2: rd_data returns the last value written to the register chosen by rd_sel, from the cycle after the write, whether or not it has been committed.
- R3: Register 0 stores and commits only bit 3 (write-control flag, output wc_bit) and bits 2:0 (device select, output dev_sel); all other bits read and commit as 0.
- R4: With wc_bit = 0 and the store idle, an ordinary write captured at clock edge E makes nv_req high in the cycle that follows edge E+1. In that cycle nv_addr is the register index and nv_data the written value.
- R5: A write to register 0 is always committed, also when wc_bit is 1.
- R6: With wc_bit = 1, writes to ordinary registers produce no store request by themselves.
- R7: A commit_cmd pulse commits every register modified since its last commit. A second commit_cmd with no writes in between issues nothing.
- R8: Commits requested while the store is busy are kept, and are issued after nv_done in ascending register index.
- R9: nv_req is a one-cycle pulse. It is raised only when nv_busy was low in the previous cycle, and never again before nv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register index for the write |
| wr_data | input | DATA_W | Write data |
| commit_cmd | input | 1 | Explicit commit request, one-cycle pulse |
| rd_sel | input | SEL_W | Register index for the read port |
| rd_data | output | DATA_W | Working value of register rd_sel |
| nv_busy | input | 1 | Store is busy with a write |
| nv_done | input | 1 | Store finished a write, one-cycle pulse |
| nv_req | output | 1 | Store write request, one-cycle pulse |
| nv_addr | output | SEL_W | Register index being committed |
| nv_data | output | DATA_W | Data being committed |
| dev_sel | output | 3 | Device-select code from register 0 |
| wc_bit | output | 1 | Write-control flag from register 0 |

## Verification
Register contents, wc_bit and dev_sel change at the edge that captures a write. The bench reads them at the falling edge that follows. A store request appears in the cycle after the next rising edge: one edge to set the pending flag and one to leave ST_IDLE. The bench checks that nv_req is still low at the first falling edge and high at the second. Every other request is matched by a falling-edge monitor against a queue of expected address/data pairs, in the order the requirements fix. A request with nothing queued is a failure, and so is an entry left over at the end.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } commit_state_t;

endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int          NREG        = 4,
    parameter int          DATA_W      = 16,
    parameter int          SEL_W       = 2,
    parameter logic [15:0] CTL_MASK    = 16'h000F,
    parameter logic [15:0] ORD_DEFAULT = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SEL_W-1:0]  cap_sel,
    output logic [DATA_W-1:0] cap_data,
    output logic [DATA_W-1:0] ctl_q
);

    localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTL_MASK);
    localparam logic [DATA_W-1:0] DEF_W  = DATA_W'(ORD_DEFAULT);

    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= (i == 0) ? '0 : DEF_W;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    regs_q[i] <= (i == 0) ? (wr_data & MASK_W) : wr_data;
                end
            end
        end
    end

    assign rd_data  = regs_q[rd_sel];
    assign cap_data = regs_q[cap_sel];
    assign ctl_q    = regs_q[0];

endmodule

// File: rtl/cfg_dirty_track.sv
module cfg_dirty_track #(
    parameter int NREG  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wc,
    input  logic             commit_cmd,
    input  logic             clr_en,
    output logic             any_pend,
    output logic [SEL_W-1:0] pick_sel
);

    logic [NREG-1:0] pend_q, pend_d;
    logic [NREG-1:0] mod_q,  mod_d;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flag
            logic hit_w;
            logic auto_c;
            logic hit_c;
            assign hit_w  = wr_en && (wr_sel == SEL_W'(g));
            assign auto_c = (g == 0) || !wc;
            assign hit_c  = clr_en && (pick_sel == SEL_W'(g));
            assign pend_d[g] = (hit_w && auto_c) ? 1'b1 :
                               hit_c             ? 1'b0 :
                               (pend_q[g] || (commit_cmd && mod_q[g]));
            assign mod_d[g]  = hit_w ? 1'b1 :
                               hit_c ? 1'b0 : mod_q[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mod_q  <= '0;
        end else begin
            pend_q <= pend_d;
            mod_q  <= mod_d;
        end
    end

    always_comb begin
        pick_sel = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_sel = SEL_W'(i);
        end
    end

    assign any_pend = |pend_q;

    assert_ctl_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> pend_q[0]);

    assert_hold_ordinary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != '0 && wc && !commit_cmd && !pend_q[wr_sel])
        |=> !pend_q[$past(wr_sel)]);

endmodule

// File: rtl/cfg_commit_fsm.sv
module cfg_commit_fsm
    import cfg_commit_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_pend,
    input  logic [SEL_W-1:0]  pick_sel,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              nv_busy,
    input  logic              nv_done,
    output logic              clr_en,
    output logic              nv_req,
    output logic [SEL_W-1:0]  nv_addr,
    output logic [DATA_W-1:0] nv_data
);

    commit_state_t state_q, state_d;
    logic [SEL_W-1:0]  addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_pend && !nv_busy) state_d = ST_SEND;
            ST_SEND: state_d = ST_WAIT;
            ST_WAIT: if (nv_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (clr_en) begin
                addr_q <= pick_sel;
                data_q <= cap_data;
            end
        end
    end

    always_comb begin
        clr_en = 1'b0;
        nv_req = 1'b0;
        unique case (state_q)
            ST_IDLE: clr_en = any_pend && !nv_busy;
            ST_SEND: nv_req = 1'b1;
            ST_WAIT: ;
            default: ;
        endcase
    end

    assign nv_addr = addr_q;
    assign nv_data = data_q;

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    assert_req_store_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> $past(!nv_busy));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !nv_done) |=> !nv_req);

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl #(
    parameter int          NREG        = 4,
    parameter int          DATA_W      = 16,
    parameter int          WC_POS      = 3,
    parameter int          DEVSEL_W    = 3,
    parameter logic [15:0] ORD_DEFAULT = 16'h0000,
    localparam int         SEL_W       = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                commit_cmd,
    input  logic [SEL_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                nv_busy,
    input  logic                nv_done,
    output logic                nv_req,
    output logic [SEL_W-1:0]    nv_addr,
    output logic [DATA_W-1:0]   nv_data,
    output logic [DEVSEL_W-1:0] dev_sel,
    output logic                wc_bit
);

    localparam logic [15:0] CTL_MASK = (16'h1 << WC_POS) | ((16'h1 << DEVSEL_W) - 16'h1);
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTL_MASK);

    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] cap_data;
    logic [SEL_W-1:0]  pick_sel;
    logic              any_pend;
    logic              clr_en;

    cfg_regfile #(
        .NREG(NREG), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .CTL_MASK(CTL_MASK), .ORD_DEFAULT(ORD_DEFAULT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .cap_sel(pick_sel), .cap_data(cap_data),
        .ctl_q(ctl_q)
    );

    assign wc_bit  = ctl_q[WC_POS];
    assign dev_sel = ctl_q[DEVSEL_W-1:0];

    cfg_dirty_track #(
        .NREG(NREG), .SEL_W(SEL_W)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wc(wc_bit),
        .commit_cmd(commit_cmd), .clr_en(clr_en),
        .any_pend(any_pend), .pick_sel(pick_sel)
    );

    cfg_commit_fsm #(
        .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .any_pend(any_pend), .pick_sel(pick_sel), .cap_data(cap_data),
        .nv_busy(nv_busy), .nv_done(nv_done),
        .clr_en(clr_en), .nv_req(nv_req),
        .nv_addr(nv_addr), .nv_data(nv_data)
    );

    assert_ctl_commit_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_addr == '0) |-> ((nv_data & ~MASK_W) == '0));

    assert_devsel_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (dev_sel == $past(wr_data[DEVSEL_W-1:0])));

endmodule

// File: tb/cfg_commit_ctrl_tb.sv
module cfg_commit_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG   = 4;
    localparam int DATA_W = 16;
    localparam int SEL_W  = 2;
    localparam int ST_LAT = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [SEL_W-1:0]  wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              commit_cmd = 1'b0;
    logic [SEL_W-1:0]  rd_sel = '0;
    logic [DATA_W-1:0] rd_data;
    logic              nv_busy = 1'b0;
    logic              nv_done = 1'b0;
    logic              nv_req;
    logic [SEL_W-1:0]  nv_addr;
    logic [DATA_W-1:0] nv_data;
    logic [2:0]        dev_sel;
    logic              wc_bit;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    int st_cnt = 0;
    bit finished = 0;
    logic [SEL_W+DATA_W-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_commit_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .commit_cmd(commit_cmd),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .nv_busy(nv_busy), .nv_done(nv_done),
        .nv_req(nv_req), .nv_addr(nv_addr), .nv_data(nv_data),
        .dev_sel(dev_sel), .wc_bit(wc_bit)
    );

    // store model: busy for ST_LAT cycles after a request, done pulse on the last
    always @(posedge clk) begin
        nv_done <= 1'b0;
        if (!rst_n) begin
            nv_busy <= 1'b0;
            st_cnt  <= 0;
        end else if (nv_req && !nv_busy) begin
            nv_busy <= 1'b1;
            st_cnt  <= ST_LAT;
        end else if (nv_busy) begin
            st_cnt <= st_cnt - 1;
            if (st_cnt == 1) begin
                nv_busy <= 1'b0;
                nv_done <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected commits as requests appear
    always @(negedge clk) begin
        if (rst_n && nv_req) begin
            req_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R7 unexpected store request", int'({nv_addr, nv_data}), 0);
            end else begin
                logic [SEL_W+DATA_W-1:0] e;
                e = exp_q.pop_front();
                chk({nv_addr, nv_data} == e, "R4/R5/R7/R8 commit addr/data",
                    int'({nv_addr, nv_data}), int'(e));
            end
        end
    end

    task automatic expect_commit(input int sel, input int data);
        exp_q.push_back({SEL_W'(sel), DATA_W'(data)});
    endtask

    task automatic do_write(input int sel, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = SEL_W'(sel);
        wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit_cmd = 1'b1;
        @(negedge clk);
        commit_cmd = 1'b0;
    endtask

    task automatic read_chk(input int sel, input int exp, input string tag);
        rd_sel = SEL_W'(sel);
        #1;
        chk(rd_data == DATA_W'(exp), tag, int'(rd_data), exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(wc_bit == 1'b0, "R1 wc_bit reset", int'(wc_bit), 0);
        chk(dev_sel == 3'b000, "R1 dev_sel reset", int'(dev_sel), 0);
        chk(nv_req == 1'b0, "R1 nv_req idle", int'(nv_req), 0);
        for (int i = 0; i < NREG; i++) read_chk(i, 0, "R1 register default");

        // R4: automatic commit with exact latency
        expect_commit(1, 16'h1234);
        do_write(1, 16'h1234);
        chk(nv_req == 1'b0, "R4 request not before edge E+1", int'(nv_req), 0);
        read_chk(1, 16'h1234, "R2 readback after write");
        @(negedge clk);
        chk(nv_req == 1'b1, "R4 request after edge E+1", int'(nv_req), 1);
        settle(12);

        // R3: reserved bits forced to zero, committed masked
        expect_commit(0, 16'h0005);
        do_write(0, 16'hFFF5);
        read_chk(0, 16'h0005, "R3 reserved bits read zero");
        chk(dev_sel == 3'd5, "R3 dev_sel", int'(dev_sel), 5);
        chk(wc_bit == 1'b0, "R3 wc_bit clear", int'(wc_bit), 0);
        settle(12);

        // R5: control write committed although it sets wc
        expect_commit(0, 16'h000D);
        do_write(0, 16'h000D);
        chk(wc_bit == 1'b1, "R3 wc_bit set", int'(wc_bit), 1);
        settle(12);

        // R6: ordinary writes held with wc set
        snap = req_cnt;
        do_write(2, 16'hAAAA);
        do_write(3, 16'hBBBB);
        do_write(1, 16'h1111);
        settle(20);
        chk(req_cnt == snap, "R6 no request with wc set", req_cnt, snap);
        read_chk(2, 16'hAAAA, "R2 uncommitted readback");
        read_chk(1, 16'h1111, "R2 overwritten readback");

        // R7: explicit commit writes modified registers in order
        expect_commit(1, 16'h1111);
        expect_commit(2, 16'hAAAA);
        expect_commit(3, 16'hBBBB);
        do_commit();
        settle(40);
        chk(exp_q.size() == 0, "R7 all modified committed", exp_q.size(), 0);
        snap = req_cnt;
        do_commit();
        settle(20);
        chk(req_cnt == snap, "R7 second commit issues nothing", req_cnt, snap);

        // R8: queued commits while store busy, ascending order
        expect_commit(0, 16'h0002);
        expect_commit(1, 16'h1010);
        expect_commit(3, 16'h3333);
        do_write(0, 16'h0002);
        do_write(3, 16'h3333);
        do_write(1, 16'h1010);
        chk(nv_busy == 1'b1, "R8 store busy during queued writes", int'(nv_busy), 1);
        settle(40);
        chk(exp_q.size() == 0, "R8 queued commits drained", exp_q.size(), 0);
        chk(dev_sel == 3'd2 && wc_bit == 1'b0, "R3 final control fields",
            int'({wc_bit, dev_sel}), 2);

        summary();
    end

endmodule